// File: doc/BRIEF.md
# Configurable Integer Divide/Modulus Unit

A multi-cycle 32-bit integer divider that returns either the quotient or the remainder of one operation per start strobe. The core is a restoring shift-subtract loop that runs on operand magnitudes. In signed mode a sign fix-up follows the loop: the quotient truncates toward zero and the remainder takes the sign of the dividend.

An 8-bit mode byte chooses the arithmetic and sets a policy for each of the two corner cases. The first corner case is a zero divisor. The second is the most negative value divided by -1 in signed mode. For each case the policy either raises an exception, which produces no write, or replaces the result with a fixed value (minimum, zero or maximum) and raises both the carry and overflow indications. Corner cases finish in one cycle. A normal division takes the full iteration count plus one fix-up cycle.

Top module: `idiv_unit`

## Requirements
- R1: With mode bit 4 clear the operands are unsigned; rem_sel_i=0 returns the quotient and rem_sel_i=1 returns the remainder.
- R2: With mode bit 4 set the operands are two's complement; the quotient truncates toward zero and a non-zero remainder has the sign of the dividend.
- R3: A zero divisor with mode bits [3:2]=00 completes with exc_o=0x0A.
- R4: A zero divisor with mode bits [3:2] of 01, 10 or 11 returns the minimum, zero or maximum value. Minimum and maximum are 0x80000000 and 0x7FFFFFFF in signed mode, and 0x00000000 and 0xFFFFFFFF in unsigned mode.
- R5: In signed mode, 0x80000000 divided by 0xFFFFFFFF with mode bits [1:0]=00 completes with exc_o=0x0B.
- R6: For that same signed case, mode bits [1:0] of 01, 10 or 11 return the minimum, zero or maximum value as in R4. In unsigned mode these operands are an ordinary division.
- R7: A substituted result sets carry_o and ovf_o to 1; an ordinary result clears both.
- R8: The corner-case policies apply in the same way when the remainder is selected.
- R9: An exception completes with res_valid_o=0 and result_o=0; every other completion has res_valid_o=1 and exc_o=0x00.
- R10: done_o is high for exactly one cycle per operation. For a corner case it is high in the cycle after the edge that samples start_i. For an ordinary division it is high after the 33rd edge following that edge (W+1 edges).
- R11: A start_i pulse that arrives while a division is in progress is ignored.
- R12: Mode bits [7:5] have no effect.
- R13: result_o, carry_o, ovf_o, exc_o and res_valid_o change only in a cycle where done_o is high, and hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor |
| mode_i | input | 8 | Signedness and corner-case policies |
| rem_sel_i | input | 1 | 0 selects the quotient, 1 selects the remainder |
| result_o | output | 32 | Quotient, remainder or substitute value |
| carry_o | output | 1 | Set when a substitute value was produced |
| ovf_o | output | 1 | Set when a substitute value was produced |
| exc_o | output | 8 | Exception code, 0x00 when none |
| res_valid_o | output | 1 | Result may be written |
| done_o | output | 1 | Completion strobe |

## Verification
The assertions check the following on every cycle:
- a trapping zero divisor or a trapping signed overflow completes on the next cycle with its code and no write;
- an exception never comes with a valid result;
- carry and overflow always agree;
- the outputs hold between completions;
- a start during a running division never produces a trap.

Only the bench scenarios can show the following:
- the arithmetic values, including signed truncation and the sign of the remainder;
- the exact latency of ordinary divisions;
- each substitute value for every signedness;
- the effect of a start ignored mid-run.

The bench shows these by comparing the outputs against a behavioural model on every clock.

// File: rtl/idiv_pkg.sv
package idiv_pkg;
  localparam int unsigned MODE_W   = 8;
  localparam int unsigned SIGN_BIT = 4;
  localparam int unsigned EXC_W    = 8;

  typedef enum logic [1:0] {
    POL_TRAP = 2'b00,
    POL_MIN  = 2'b01,
    POL_ZERO = 2'b10,
    POL_MAX  = 2'b11
  } corner_pol_e;

  localparam logic [EXC_W-1:0] EXC_NONE   = 8'h00;
  localparam logic [EXC_W-1:0] EXC_DIV0   = 8'h0A;
  localparam logic [EXC_W-1:0] EXC_SOVF   = 8'h0B;
endpackage

// File: rtl/idiv_corner.sv
module idiv_corner
  import idiv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]     dvd_i,
  input  logic [W-1:0]     dvs_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic             hit_o,
  output logic             trap_o,
  output logic [EXC_W-1:0] code_o,
  output logic [W-1:0]     subst_o
);
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};

  logic        sgn, zdiv, sovf;
  corner_pol_e pol;

  assign sgn  = mode_i[SIGN_BIT];
  assign zdiv = (dvs_i == '0);
  assign sovf = sgn && (dvd_i == SMIN) && (dvs_i == '1);

  always_comb begin
    pol    = POL_TRAP;
    code_o = EXC_NONE;
    if (zdiv) begin
      pol    = corner_pol_e'(mode_i[3:2]);
      code_o = EXC_DIV0;
    end else if (sovf) begin
      pol    = corner_pol_e'(mode_i[1:0]);
      code_o = EXC_SOVF;
    end
    case (pol)
      POL_MIN:  subst_o = sgn ? SMIN : '0;
      POL_MAX:  subst_o = sgn ? SMAX : '1;
      default:  subst_o = '0;
    endcase
  end

  assign hit_o  = zdiv || sovf;
  assign trap_o = hit_o && (pol == POL_TRAP);
endmodule

// File: rtl/idiv_core.sv
module idiv_core #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         fin_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W:0]    rem_q;
  logic [W-1:0]  quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          fin_q;
  logic [W:0]    shifted, trial;
  logic          take;

  assign shifted = {rem_q[W-1:0], quo_q[W-1]};
  assign trial   = shifted - {1'b0, dvs_q};
  assign take    = !trial[W];  // no borrow

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      fin_q <= 1'b0;
    end else if (load_i) begin
      rem_q <= '0;
      quo_q <= dvd_i;
      dvs_q <= dvs_i;
      cnt_q <= CW'(W);
      fin_q <= 1'b0;
    end else if (cnt_q != '0) begin
      rem_q <= take ? trial : shifted;
      quo_q <= {quo_q[W-2:0], take};
      cnt_q <= cnt_q - 1'b1;
      fin_q <= (cnt_q == CW'(1));
    end else begin
      fin_q <= 1'b0;
    end
  end

  assign fin_o = fin_q;
  assign quo_o = quo_q;
  assign rem_o = rem_q[W-1:0];
endmodule

// File: rtl/idiv_unit.sv
module idiv_unit
  import idiv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [W-1:0]      dividend_i,
  input  logic [W-1:0]      divisor_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              rem_sel_i,
  output logic [W-1:0]      result_o,
  output logic              carry_o,
  output logic              ovf_o,
  output logic [EXC_W-1:0]  exc_o,
  output logic              res_valid_o,
  output logic              done_o
);
  logic             busy_q, neg_q_q, neg_r_q, sel_q;
  logic             accept, sgn, neg_a, neg_b;
  logic [W-1:0]     mag_a, mag_b;
  logic             hit, trap;
  logic [EXC_W-1:0] code;
  logic [W-1:0]     subst;
  logic             fin;
  logic [W-1:0]     quo, rem, quo_fix, rem_fix;

  assign accept = start_i && !busy_q;
  assign sgn    = mode_i[SIGN_BIT];
  assign neg_a  = sgn && dividend_i[W-1];
  assign neg_b  = sgn && divisor_i[W-1];
  assign mag_a  = neg_a ? -dividend_i : dividend_i;
  assign mag_b  = neg_b ? -divisor_i  : divisor_i;

  idiv_corner #(.W(W)) corner_i (
    .dvd_i  (dividend_i),
    .dvs_i  (divisor_i),
    .mode_i (mode_i),
    .hit_o  (hit),
    .trap_o (trap),
    .code_o (code),
    .subst_o(subst)
  );

  idiv_core #(.W(W)) core_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept && !hit),
    .dvd_i (mag_a),
    .dvs_i (mag_b),
    .fin_o (fin),
    .quo_o (quo),
    .rem_o (rem)
  );

  assign quo_fix = neg_q_q ? -quo : quo;
  assign rem_fix = neg_r_q ? -rem : rem;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      neg_q_q     <= 1'b0;
      neg_r_q     <= 1'b0;
      sel_q       <= 1'b0;
      result_o    <= '0;
      carry_o     <= 1'b0;
      ovf_o       <= 1'b0;
      exc_o       <= EXC_NONE;
      res_valid_o <= 1'b0;
      done_o      <= 1'b0;
    end else if (accept && hit) begin
      done_o      <= 1'b1;
      result_o    <= trap ? '0 : subst;
      carry_o     <= !trap;
      ovf_o       <= !trap;
      exc_o       <= trap ? code : EXC_NONE;
      res_valid_o <= !trap;
    end else if (accept) begin
      busy_q  <= 1'b1;
      neg_q_q <= neg_a ^ neg_b;
      neg_r_q <= neg_a;
      sel_q   <= rem_sel_i;
      done_o  <= 1'b0;
    end else if (busy_q && fin) begin
      busy_q      <= 1'b0;
      done_o      <= 1'b1;
      result_o    <= sel_q ? rem_fix : quo_fix;
      carry_o     <= 1'b0;
      ovf_o       <= 1'b0;
      exc_o       <= EXC_NONE;
      res_valid_o <= 1'b1;
    end else begin
      done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/idiv_unit_chk.sv
module idiv_unit_chk
  import idiv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [W-1:0]      dividend_i,
  input logic [W-1:0]      divisor_i,
  input logic [MODE_W-1:0] mode_i,
  input logic              busy,
  input logic [W-1:0]      result_o,
  input logic              carry_o,
  input logic              ovf_o,
  input logic [EXC_W-1:0]  exc_o,
  input logic              res_valid_o,
  input logic              done_o
);
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  AST_ZERO_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy && divisor_i == '0 && mode_i[3:2] == 2'b00)
    |=> (done_o && exc_o == EXC_DIV0)); // R3

  AST_SOVF_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy && mode_i[SIGN_BIT] && dividend_i == SMIN &&
     divisor_i == '1 && mode_i[1:0] == 2'b00)
    |=> (done_o && exc_o == EXC_SOVF)); // R5

  AST_FLAGS_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (carry_o == ovf_o)); // R7

  AST_EXC_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && exc_o != EXC_NONE) |-> (!res_valid_o && result_o == '0)); // R9

  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy) |=> !(done_o && exc_o != EXC_NONE)); // R11

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(result_o) && $stable(exc_o) && $stable(res_valid_o))); // R13
endmodule

bind idiv_unit idiv_unit_chk #(.W(W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .dividend_i (dividend_i),
  .divisor_i  (divisor_i),
  .mode_i     (mode_i),
  .busy       (busy_q),
  .result_o   (result_o),
  .carry_o    (carry_o),
  .ovf_o      (ovf_o),
  .exc_o      (exc_o),
  .res_valid_o(res_valid_o),
  .done_o     (done_o)
);

// File: tb/idiv_unit_tb_top.sv
module idiv_unit_tb_top;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  dvd = '0, dvs = '0;
  logic [7:0]    mode = '0;
  logic          sel = 1'b0;
  logic [W-1:0]  result;
  logic          carry, ovf, valid, done;
  logic [7:0]    exc;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  idiv_unit #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dividend_i(dvd),
    .divisor_i(dvs), .mode_i(mode), .rem_sel_i(sel), .result_o(result),
    .carry_o(carry), .ovf_o(ovf), .exc_o(exc), .res_valid_o(valid), .done_o(done)
  );

  typedef struct {
    logic [31:0] res;
    logic        flag;
    logic [7:0]  exc;
    logic        valid;
    int          lat;
  } exp_t;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      summary();
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                 input logic [7:0] m, input logic s);
    exp_t e;
    bit sg = m[4];
    logic [1:0] pol;
    bit corner = 0;
    logic [7:0] code = 8'h00;
    e.res = 0; e.flag = 0; e.exc = 0; e.valid = 1; e.lat = W + 2;
    if (b == 0) begin corner = 1; pol = m[3:2]; code = 8'h0A; end
    else if (sg && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
      corner = 1; pol = m[1:0]; code = 8'h0B;
    end
    if (corner) begin
      e.lat = 1;
      case (pol)
        2'd0: begin e.exc = code; e.valid = 0; end
        2'd1: begin e.res = sg ? 32'h8000_0000 : 32'h0; e.flag = 1; end
        2'd2: begin e.res = 32'h0; e.flag = 1; end
        default: begin e.res = sg ? 32'h7FFF_FFFF : 32'hFFFF_FFFF; e.flag = 1; end
      endcase
    end else if (sg) begin
      int sa = int'(a);
      int sb = int'(b);
      e.res = s ? 32'(sa % sb) : 32'(sa / sb);
    end else begin
      e.res = s ? a % b : a / b;
    end
    return e;
  endfunction

  // poke_at > 0 pulses a second start with other operands mid-run
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [7:0] m,
                        input logic s, input string tag, input int poke_at = 0);
    exp_t e = model(a, b, m, s);
    int cnt;
    dvd = a; dvs = b; mode = m; sel = s; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    while (!done && cnt < 100) begin
      if (cnt == poke_at) begin
        dvd = 32'd7; dvs = 32'd0; mode = 8'h00; sel = 1'b0; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      cnt++;
    end
    check(cnt == e.lat, {tag, " R10 latency"}, cnt, e.lat);
    check(result == e.res, {tag, " result"}, result, e.res);
    check(carry == e.flag && ovf == e.flag, {tag, " R7 carry/ovf"}, {carry, ovf}, {e.flag, e.flag});
    check(exc == e.exc, {tag, " R9 exc"}, exc, e.exc);
    check(valid == e.valid, {tag, " R9 valid"}, valid, e.valid);
    @(negedge clk);
    check(!done, {tag, " R10 single pulse"}, done, 0);
    check(result == e.res && exc == e.exc, {tag, " R13 hold"}, result, e.res);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !valid && result == 0 && exc == 0, "reset state", result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 unsigned
    run_op(32'd100, 32'd7, 8'h00, 1'b0, "R1 udiv");
    run_op(32'd100, 32'd7, 8'h00, 1'b1, "R1 umod");
    run_op(32'hFFFF_FFFF, 32'd1, 8'h00, 1'b0, "R1 umax");
    run_op(32'hFFFF_FFF0, 32'd3, 8'h00, 1'b1, "R1 big mod");
    // R2 signed
    run_op(-32'sd100, 32'd7, 8'h10, 1'b0, "R2 neg/pos q");
    run_op(-32'sd100, 32'd7, 8'h10, 1'b1, "R2 neg/pos r");
    run_op(32'd100, -32'sd7, 8'h10, 1'b0, "R2 pos/neg q");
    run_op(32'd100, -32'sd7, 8'h10, 1'b1, "R2 pos/neg r");
    run_op(-32'sd100, -32'sd7, 8'h10, 1'b1, "R2 neg/neg r");
    run_op(32'h8000_0000, 32'd2, 8'h10, 1'b0, "R2 min/2");
    // R3 R4 R8 zero divisor
    for (int sg = 0; sg < 2; sg++)
      for (int p = 0; p < 4; p++)
        for (int s = 0; s < 2; s++)
          run_op(32'd55, 32'd0, 8'((sg << 4) | (p << 2)), 1'(s), "R3/R4/R8 div0");
    // R5 R6 R8 signed overflow
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 2; s++)
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 8'(16 | p), 1'(s), "R5/R6/R8 sovf");
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 8'h00, 1'b0, "R6 unsigned not corner q");
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 8'h00, 1'b1, "R6 unsigned not corner r");
    // R12 upper mode bits
    run_op(-32'sd100, 32'd7, 8'hF0, 1'b1, "R12 upper bits signed");
    run_op(32'd9, 32'd0, 8'hE4, 1'b0, "R12 upper bits div0");
    // R11 start ignored while busy
    run_op(32'd1000, 32'd9, 8'h00, 1'b0, "R11 busy start", 5);
    // mixed operands
    begin
      logic [31:0] x = 32'h1234_5678;
      for (int i = 0; i < 40; i++) begin
        logic [31:0] a, b;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        a = x;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        b = (i % 3 == 0) ? (x >> (x[4:0])) : x;
        run_op(a, b, 8'(x[7:0] & 8'h1F), x[8], "R1/R2 mixed");
      end
    end
    summary();
  end
endmodule